// File: doc/BRIEF.md
# Addressable LED Frame Serializer

This block holds a frame of colour bytes and plays it out on a single self-clocked LED data wire. Software-side logic appends bytes one at a time into an internal buffer. A start request then sends every stored byte, in storage order, as a train of fixed-period bits. In each bit the width of the high pulse tells the LEDs whether the bit is a zero or a one. Bytes follow each other with no gap, because the next byte is read from the buffer while the current one is still going out.

After the final bit the wire is held low for a long latch interval, so the LED chain takes the new colours. From the accepted start request until that interval ends, the block pulls a shared open-drain busy line low. When the interval ends it empties the buffer and releases the line. Coming out of reset, the block first writes zeros into every buffer slot and sends that full frame once, so the whole strip begins dark. Every time value is a parameter counted in system clock cycles.

Top module: `led_frame_serializer`

## Requirements
- R1: After reset the block writes zero to all DEPTH buffer slots and then sends all DEPTH bytes (all zero). The busy pull is asserted and the data line is low in the first cycle after reset.
- R2: While idle, each write cycle (wr_en high, go low) stores wr_byte at slot fill_level and raises fill_level by one. Once fill_level equals DEPTH, further writes are dropped and fill_level stays at DEPTH.
- R3: A go pulse while idle with fill_level nonzero starts a transfer. A go pulse with fill_level zero is ignored: the busy pull stays released and the data line stays low.
- R4: A transfer sends exactly fill_level bytes, from slot 0 upward, each byte most significant bit first.
- R5: Every bit begins with a rising edge T_BIT_CYC cycles after the previous one within a transfer, including across byte boundaries. The high time is T_ZERO_HI cycles for a 0 bit and T_ONE_HI cycles for a 1 bit.
- R6: After the last bit falls, the data line stays low for at least T_LATCH cycles before the busy pull is released.
- R7: latch_pull_low goes high in the cycle after go is accepted and stays high until the latch interval ends. Outside transfers and the reset frame it is low.
- R8: When the busy pull is released, fill_level is zero.
- R9: Writes presented while busy are ignored: fill_level does not change during a transfer.
- R10: The data line is low whenever no bit is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Append wr_byte to the buffer this cycle |
| wr_byte | input | 8 | Byte to append |
| go | input | 1 | Request to send the buffered frame |
| led_dout | output | 1 | Self-clocked LED data line, idles low |
| latch_pull_low | output | 1 | 1 = drive the shared busy line low; 0 = release it |
| fill_level | output | $clog2(DEPTH+1) | Number of bytes now in the buffer |

## Verification
The assertions assume that go is raised only as a request, not as a level that also carries writes. They also assume that T_ONE_HI and T_ZERO_HI are both shorter than T_BIT_CYC, so every bit ends with a low phase. The stimulus drives all inputs on the falling edge, keeps go to single-cycle pulses, and never raises wr_en in the same cycle as go. It decodes the wire only by pulse widths and edge spacing. The bench uses a short bit period, a short latch interval and an eight-byte buffer. This makes the overflow case and the full reset frame cheap to reach.

// File: rtl/ledser_pkg.sv
package ledser_pkg;
  typedef enum logic [2:0] {
    S_CLR,
    S_IDLE,
    S_PREP,
    S_FIRST,
    S_SEND,
    S_GAP
  } ledser_st_e;
endpackage

// File: rtl/ledser_ram.sv
module ledser_ram #(
  parameter int DEPTH = 450,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ledser_shaper.sv
module ledser_shaper #(
  parameter int T_BIT_CYC = 125,
  parameter int T_ZERO_HI = 40,
  parameter int T_ONE_HI  = 80
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       done,
  output logic       active,
  output logic       dout
);
  localparam int PW = $clog2(T_BIT_CYC);
  localparam logic [PW-1:0] P_LAST = PW'(T_BIT_CYC - 1);
  localparam logic [PW-1:0] P_ZERO = PW'(T_ZERO_HI);
  localparam logic [PW-1:0] P_ONE  = PW'(T_ONE_HI);

  logic [PW-1:0] phase;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          hi;

  assign done = active && (phase == P_LAST) && (bitn == 3'd7);
  assign hi   = active && (phase < (sh[7] ? P_ONE : P_ZERO));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= '0;
      bitn   <= '0;
      sh     <= '0;
      dout   <= 1'b0;
    end else begin
      dout <= hi;
      if (load) begin
        active <= 1'b1;
        sh     <= byte_in;
        bitn   <= '0;
        phase  <= '0;
      end else if (active) begin
        if (phase == P_LAST) begin
          phase <= '0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R5
  load_slot_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (!active || done));

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= P_LAST);

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !$past(active)) |-> !dout);
endmodule

// File: rtl/led_frame_serializer.sv
module led_frame_serializer
  import ledser_pkg::*;
#(
  parameter int DEPTH     = 450,
  parameter int T_BIT_CYC = 125,
  parameter int T_ZERO_HI = 40,
  parameter int T_ONE_HI  = 80,
  parameter int T_LATCH   = 5000,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          go,
  output logic          led_dout,
  output logic          latch_pull_low,
  output logic [CW-1:0] fill_level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int GW = $clog2(T_LATCH + 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [GW-1:0] GAP_LAST = GW'(T_LATCH - 1);

  ledser_st_e    st;
  logic [CW-1:0] cnt, idx, left;
  logic [GW-1:0] gcnt;
  logic          ram_we, ram_re;
  logic [AW-1:0] ram_wa, ram_ra;
  logic [7:0]    ram_wd, ram_q;
  logic          sh_load, sh_done, sh_active;
  logic          take_wr;

  assign fill_level = cnt;
  assign take_wr    = wr_en && !go && (cnt < DEPTH_C);

  ledser_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .re(ram_re), .raddr(ram_ra), .rdata(ram_q)
  );

  ledser_shaper #(.T_BIT_CYC(T_BIT_CYC), .T_ZERO_HI(T_ZERO_HI), .T_ONE_HI(T_ONE_HI)) u_shp (
    .clk(clk), .rst(rst), .load(sh_load), .byte_in(ram_q),
    .done(sh_done), .active(sh_active), .dout(led_dout)
  );

  always_comb begin
    ram_we  = 1'b0;
    ram_wa  = cnt[AW-1:0];
    ram_wd  = wr_byte;
    ram_re  = 1'b0;
    ram_ra  = idx[AW-1:0];
    sh_load = 1'b0;
    case (st)
      S_CLR: begin
        ram_we = 1'b1;
        ram_wa = idx[AW-1:0];
        ram_wd = 8'h00;
      end
      S_IDLE:  ram_we = take_wr;
      S_PREP:  ram_re = 1'b1;
      S_FIRST: begin
        sh_load = 1'b1;
        ram_re  = (idx < cnt);
      end
      S_SEND: begin
        if (sh_done && (left != '0)) begin
          sh_load = 1'b1;
          ram_re  = (idx < cnt);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_CLR;
      cnt            <= '0;
      idx            <= '0;
      left           <= '0;
      gcnt           <= '0;
      latch_pull_low <= 1'b1;
    end else begin
      case (st)
        S_CLR: begin
          if (idx == DEPTH_C - 1'b1) begin
            cnt <= DEPTH_C;
            idx <= '0;
            st  <= S_PREP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_IDLE: begin
          if (go && (cnt != '0)) begin
            idx            <= '0;
            st             <= S_PREP;
            latch_pull_low <= 1'b1;
          end else if (take_wr) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PREP: begin
          idx <= idx + 1'b1;
          st  <= S_FIRST;
        end
        S_FIRST: begin
          left <= cnt - 1'b1;
          if (ram_re) idx <= idx + 1'b1;
          st <= S_SEND;
        end
        S_SEND: begin
          if (sh_done) begin
            if (left != '0) begin
              left <= left - 1'b1;
              if (ram_re) idx <= idx + 1'b1;
            end else begin
              gcnt <= '0;
              st   <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gcnt == GAP_LAST) begin
            cnt            <= '0;
            latch_pull_low <= 1'b0;
            st             <= S_IDLE;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_level <= DEPTH_C);

  // R8
  release_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_pull_low) |-> (fill_level == '0));

  // R9
  busy_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_PREP || st == S_FIRST || st == S_SEND) |=> $stable(fill_level));

  // R6
  gap_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_GAP || st == S_IDLE) |-> !led_dout);

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !(go && fill_level != '0)) |=> !latch_pull_low);

  // R3
  empty_go_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && go && fill_level == '0) |=> (!latch_pull_low && !led_dout));
endmodule

// File: tb/tb_led_frame_serializer.sv
module tb_led_frame_serializer;
  localparam int DEPTH = 8;
  localparam int TBIT  = 10;
  localparam int T0    = 3;
  localparam int T1    = 7;
  localparam int TGAP  = 20;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic go = 1'b0;
  logic led_dout, latch_pull_low;
  logic [CW-1:0] fill_level;

  int total = 0;
  int bad = 0;
  byte unsigned exp_q[$];
  byte unsigned pend[$];
  int model_fill = 0;

  always #5 clk = ~clk;

  led_frame_serializer #(
    .DEPTH(DEPTH), .T_BIT_CYC(TBIT), .T_ZERO_HI(T0), .T_ONE_HI(T1), .T_LATCH(TGAP)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .go(go),
    .led_dout(led_dout), .latch_pull_low(latch_pull_low), .fill_level(fill_level)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: decodes the line at the falling edge and pops expected bytes
  logic prev_d = 1'b0, prev_b = 1'b0, in_frame = 1'b0;
  int hi_len = 0, low_len = 0, since = 0, nbits = 0;
  logic [7:0] acc = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (led_dout) begin
        if (!prev_d) begin
          // R5 rising edges one bit period apart
          if (in_frame) check(since == TBIT, "R5 period", since, TBIT);
          since = 0;
          in_frame = 1'b1;
          hi_len = 0;
        end
        hi_len++;
        low_len = 0;
      end else begin
        low_len++;
        if (prev_d) begin
          // R5 pulse width
          check(hi_len == T0 || hi_len == T1, "R5 width", hi_len, T0);
          acc = {acc[6:0], (hi_len == T1)};
          nbits++;
          if (nbits == 8) begin
            nbits = 0;
            if (exp_q.size() == 0) check(1'b0, "R4 extra byte", acc, -1);
            else begin
              byte unsigned e;
              e = exp_q.pop_front();
              check(acc == e, "R4 byte", acc, e);
            end
          end
        end
      end
      if (prev_b && !latch_pull_low) begin
        if (in_frame) check(low_len >= TGAP, "R6 latch gap", low_len, TGAP);
        check(fill_level == 0, "R8 fill at release", fill_level, 0);
        check(exp_q.size() == 0 && nbits == 0, "R4 byte count", exp_q.size(), 0);
        in_frame = 1'b0;
      end
      prev_d = led_dout;
      prev_b = latch_pull_low;
    end
  end

  task automatic wr(input byte unsigned b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (model_fill < DEPTH) begin
      pend.push_back(b);
      model_fill++;
    end
    // R2 append and saturation
    check(fill_level == model_fill, "R2 fill", fill_level, model_fill);
  endtask

  task automatic wait_idle();
    while (latch_pull_low) @(negedge clk);
  endtask

  task automatic send();
    @(negedge clk);
    go = 1'b1;
    foreach (pend[i]) exp_q.push_back(pend[i]);
    pend.delete();
    @(negedge clk);
    go = 1'b0;
    // R7 busy asserted one cycle after accepted go
    check(latch_pull_low == 1'b1, "R7 busy on start", latch_pull_low, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_q.push_back(8'h00);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(latch_pull_low == 1'b1, "R1 busy after reset", latch_pull_low, 1);
    check(led_dout == 1'b0, "R10 line low after reset", led_dout, 0);
    wait_idle();
    model_fill = 0;
    check(fill_level == 0, "R1 frame done", fill_level, 0);

    // R3 go on empty buffer ignored
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (latch_pull_low || led_dout) begin
        check(1'b0, "R3 empty go ignored", latch_pull_low, 0);
        break;
      end
    end
    check(latch_pull_low == 1'b0, "R3 still idle", latch_pull_low, 0);

    // R4 mixed frame
    wr(8'hA5); wr(8'h3C); wr(8'hFF); wr(8'h00); wr(8'h81);
    send();
    repeat (20) @(negedge clk);
    // R9 write while busy is ignored
    wr_en = 1'b1; wr_byte = 8'h55;
    @(negedge clk);
    wr_en = 1'b0;
    check(fill_level == 5, "R9 fill stable while busy", fill_level, 5);
    @(negedge clk);
    check(fill_level == 5, "R9 write dropped", fill_level, 5);
    wait_idle();
    model_fill = 0;
    check(fill_level == 0, "R8 fill cleared", fill_level, 0);

    // R2 overflow: only DEPTH bytes kept
    for (int i = 0; i < DEPTH + 2; i++) wr(byte'(8'h10 + i * 8'h1D));
    check(fill_level == DEPTH, "R2 saturated", fill_level, DEPTH);
    send();
    wait_idle();
    model_fill = 0;

    // single byte frame
    wr(8'h01);
    send();
    wait_idle();
    model_fill = 0;
    repeat (5) @(negedge clk);
    check(led_dout == 1'b0, "R10 idle low", led_dout, 0);
    check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule